// File: doc/BRIEF.md
# Fetch/Execute Control Sequencer for an 8-bit Shared-Memory CPU

This block is the control unit of a small 8-bit processor in which instructions and data share one memory and one memory address register. The sequencer is a hard-coded finite state machine, used in place of a microcode table. Every instruction starts with the same two fetch cycles. In the first, the program counter goes to the address register. In the second, the instruction word is read into the instruction register, the program counter advances, and the next state is picked from the opcode field of the word on the bus. One or two execute cycles follow, and the machine then returns to the first fetch cycle. A halt instruction parks the machine until reset.

The block owns the program counter. It is clocked on the inverted clock, so the increment lands at the falling edge of the decode cycle and the new count is ready before the next rising edge. The instruction register, accumulator, operand register, ALU, output register and memory sit outside the block. They react to the one-hot strobes it produces. The shared bus value comes back into the block so that it can decode the opcode during fetch and load jump targets.

Top module: `cpu_seq_ctrl`

## Requirements
- R1: While the reset input is high at a rising edge, the machine enters the first fetch cycle: in the next cycle only pc_oe and mar_ld are high and halted is low. The program counter is cleared at the falling edge that follows.
- R2: In the first fetch cycle exactly pc_oe and mar_ld are asserted, and the next cycle is the second fetch cycle.
- R3: In the second fetch cycle exactly mem_oe, ir_ld and pc_inc are asserted. The next state is chosen from bus_in[7:4], the opcode field. Bits [3:0] of an instruction word are its operand.
- R4: Opcodes 1 (load A), 2 (add), 3 (subtract) and 4 (store A) each take two execute cycles. The first cycle of each asserts ir_oe and mar_ld. The second asserts mem_oe and a_ld for load; mem_oe, b_ld and alu_wr for add; the same plus alu_sub for subtract; and a_oe and mem_we for store. The machine then returns to the first fetch cycle.
- R5: The program counter changes only at falling clock edges. It increments at the falling edge of the second fetch cycle, and it takes bus_in[3:0] at the falling edge of a jump execute cycle.
- R6: Opcode 15 leads to a halt state with halted high and every other strobe low. The program counter holds its value, and the state is left only through reset.
- R7: Opcodes 0 and 7 to 13 have no execute cycle: the cycle after the second fetch cycle is the first fetch cycle.
- R8: At most one of the bus sources pc_oe, mem_oe, ir_oe and a_oe is high in any cycle.
- R9: A program that loads one memory value, adds a second, outputs the sum and halts delivers the sum to the output register and raises halted no later than 16 cycles after reset is released.
- R10: Opcodes 5 (load immediate), 6 (jump) and 14 (output) each take one execute cycle. Load immediate asserts ir_oe and a_ld, jump asserts ir_oe and pc_ld, and output asserts a_oe and out_ld. The machine then returns to the first fetch cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state on the rising edge, program counter on the falling edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_in | input | DATA_W | Value currently on the shared data bus |
| pc_oe | output | 1 | Program counter drives the bus |
| mar_ld | output | 1 | Memory address register loads from the bus |
| mem_oe | output | 1 | Memory drives the bus |
| ir_ld | output | 1 | Instruction register loads from the bus |
| pc_inc | output | 1 | Program counter advances at the falling edge |
| ir_oe | output | 1 | Operand field of the instruction register drives the bus |
| a_ld | output | 1 | Accumulator loads from the bus |
| b_ld | output | 1 | Operand register loads from the bus |
| alu_wr | output | 1 | Accumulator takes the ALU result of accumulator and bus |
| alu_sub | output | 1 | ALU subtracts instead of adding |
| a_oe | output | 1 | Accumulator drives the bus |
| mem_we | output | 1 | Memory writes the bus value at the address register |
| pc_ld | output | 1 | Program counter loads the bus operand at the falling edge |
| out_ld | output | 1 | Output register loads from the bus |
| halted | output | 1 | Machine is in the halt state |
| pc | output | ADDR_W | Program counter value |

## Verification
The hardest situations to reach from the ports are a reset that arrives partway through a multi-cycle instruction, and the half-cycle window in which the program counter has not yet advanced. The bench samples the counter twice per cycle, once before and once after the falling edge, so that the early value of the decode cycle can be compared with the late one. It asserts reset during the address cycle of an add instruction and then reruns the program. A second program puts unknown opcodes, a store, a subtract and a forward jump over an output instruction between ordinary instructions. This way each of the no-op, write-back and counter-load paths is entered from a live fetch and not from reset.

// File: rtl/cpu_seq_pkg.sv
package cpu_seq_pkg;

   localparam int OPC_W = 4;

   typedef enum logic [OPC_W-1:0] {
      OPC_NOP = 4'h0,
      OPC_LDA = 4'h1,
      OPC_ADD = 4'h2,
      OPC_SUB = 4'h3,
      OPC_STA = 4'h4,
      OPC_LDI = 4'h5,
      OPC_JMP = 4'h6,
      OPC_OUT = 4'hE,
      OPC_HLT = 4'hF
   } opcode_e;

   typedef enum logic [3:0] {
      ST_FADDR   = 4'd0,
      ST_FINSTR  = 4'd1,
      ST_LDA_ADR = 4'd2,
      ST_LDA_RD  = 4'd3,
      ST_ADD_ADR = 4'd4,
      ST_ADD_RD  = 4'd5,
      ST_SUB_ADR = 4'd6,
      ST_SUB_RD  = 4'd7,
      ST_STA_ADR = 4'd8,
      ST_STA_WR  = 4'd9,
      ST_LDI     = 4'd10,
      ST_JMP     = 4'd11,
      ST_OUT     = 4'd12,
      ST_HALT    = 4'd13
   } seq_state_e;

   typedef struct packed {
      logic halted;
      logic out_ld;
      logic pc_ld;
      logic mem_we;
      logic a_oe;
      logic alu_sub;
      logic alu_wr;
      logic b_ld;
      logic a_ld;
      logic ir_oe;
      logic pc_inc;
      logic ir_ld;
      logic mem_oe;
      logic mar_ld;
      logic pc_oe;
   } ctrl_word_t;

endpackage

// File: rtl/cpu_seq_next.sv
module cpu_seq_next
   import cpu_seq_pkg::*;
#(
   parameter int OPC_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [OPC_W-1:0] opcode,
   output seq_state_e       state
);

   seq_state_e nxt;

   always_comb begin
      nxt = ST_FADDR;
      case (state)
         ST_FADDR:   nxt = ST_FINSTR;
         ST_FINSTR: begin
            case (opcode)
               OPC_LDA: nxt = ST_LDA_ADR;
               OPC_ADD: nxt = ST_ADD_ADR;
               OPC_SUB: nxt = ST_SUB_ADR;
               OPC_STA: nxt = ST_STA_ADR;
               OPC_LDI: nxt = ST_LDI;
               OPC_JMP: nxt = ST_JMP;
               OPC_OUT: nxt = ST_OUT;
               OPC_HLT: nxt = ST_HALT;
               default: nxt = ST_FADDR;
            endcase
         end
         ST_LDA_ADR: nxt = ST_LDA_RD;
         ST_ADD_ADR: nxt = ST_ADD_RD;
         ST_SUB_ADR: nxt = ST_SUB_RD;
         ST_STA_ADR: nxt = ST_STA_WR;
         ST_HALT:    nxt = ST_HALT;
         default:    nxt = ST_FADDR;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) state <= ST_FADDR;
      else     state <= nxt;
   end

endmodule

// File: rtl/cpu_seq_strobe.sv
module cpu_seq_strobe
   import cpu_seq_pkg::*;
(
   input  seq_state_e state,
   output ctrl_word_t cw
);

   always_comb begin
      cw = '0;
      case (state)
         ST_FADDR: begin
            cw.pc_oe  = 1'b1;
            cw.mar_ld = 1'b1;
         end
         ST_FINSTR: begin
            cw.mem_oe = 1'b1;
            cw.ir_ld  = 1'b1;
            cw.pc_inc = 1'b1;
         end
         ST_LDA_ADR, ST_ADD_ADR, ST_SUB_ADR, ST_STA_ADR: begin
            cw.ir_oe  = 1'b1;
            cw.mar_ld = 1'b1;
         end
         ST_LDA_RD: begin
            cw.mem_oe = 1'b1;
            cw.a_ld   = 1'b1;
         end
         ST_ADD_RD: begin
            cw.mem_oe = 1'b1;
            cw.b_ld   = 1'b1;
            cw.alu_wr = 1'b1;
         end
         ST_SUB_RD: begin
            cw.mem_oe  = 1'b1;
            cw.b_ld    = 1'b1;
            cw.alu_wr  = 1'b1;
            cw.alu_sub = 1'b1;
         end
         ST_STA_WR: begin
            cw.a_oe   = 1'b1;
            cw.mem_we = 1'b1;
         end
         ST_LDI: begin
            cw.ir_oe = 1'b1;
            cw.a_ld  = 1'b1;
         end
         ST_JMP: begin
            cw.ir_oe = 1'b1;
            cw.pc_ld = 1'b1;
         end
         ST_OUT: begin
            cw.a_oe   = 1'b1;
            cw.out_ld = 1'b1;
         end
         ST_HALT: cw.halted = 1'b1;
         default: cw = '0;
      endcase
   end

endmodule

// File: rtl/cpu_seq_pc.sv
module cpu_seq_pc #(
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              inc,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_val,
   output logic [ADDR_W-1:0] pc
);

   localparam logic [ADDR_W-1:0] PC_STEP = ADDR_W'(1);

   // Inverted clock: the count settles half a cycle after the decode edge.
   always_ff @(negedge clk) begin
      if (rst)       pc <= '0;
      else if (load) pc <= load_val;
      else if (inc)  pc <= pc + PC_STEP;
   end

endmodule

// File: rtl/cpu_seq_ctrl.sv
module cpu_seq_ctrl
   import cpu_seq_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int OPC_W  = 4,
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DATA_W-1:0] bus_in,
   output logic              pc_oe,
   output logic              mar_ld,
   output logic              mem_oe,
   output logic              ir_ld,
   output logic              pc_inc,
   output logic              ir_oe,
   output logic              a_ld,
   output logic              b_ld,
   output logic              alu_wr,
   output logic              alu_sub,
   output logic              a_oe,
   output logic              mem_we,
   output logic              pc_ld,
   output logic              out_ld,
   output logic              halted,
   output logic [ADDR_W-1:0] pc
);

   localparam int OPC_LSB = DATA_W - OPC_W;

   if (OPC_W != cpu_seq_pkg::OPC_W) begin : g_bad_opc_w
      $error("cpu_seq_ctrl: OPC_W must match the package opcode width");
   end
   if (OPC_W + ADDR_W > DATA_W) begin : g_bad_fields
      $error("cpu_seq_ctrl: opcode and operand do not fit in DATA_W");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("cpu_seq_ctrl: ADDR_W must be at least 1");
   end

   seq_state_e       state;
   ctrl_word_t       cw;
   logic [OPC_W-1:0] opcode;

   assign opcode = bus_in[OPC_LSB +: OPC_W];

   cpu_seq_next #(.OPC_W(OPC_W)) u_next (
      .clk    (clk),
      .rst    (rst),
      .opcode (opcode),
      .state  (state)
   );

   cpu_seq_strobe u_strobe (
      .state (state),
      .cw    (cw)
   );

   cpu_seq_pc #(.ADDR_W(ADDR_W)) u_pc (
      .clk      (clk),
      .rst      (rst),
      .inc      (cw.pc_inc),
      .load     (cw.pc_ld),
      .load_val (bus_in[ADDR_W-1:0]),
      .pc       (pc)
   );

   assign pc_oe   = cw.pc_oe;
   assign mar_ld  = cw.mar_ld;
   assign mem_oe  = cw.mem_oe;
   assign ir_ld   = cw.ir_ld;
   assign pc_inc  = cw.pc_inc;
   assign ir_oe   = cw.ir_oe;
   assign a_ld    = cw.a_ld;
   assign b_ld    = cw.b_ld;
   assign alu_wr  = cw.alu_wr;
   assign alu_sub = cw.alu_sub;
   assign a_oe    = cw.a_oe;
   assign mem_we  = cw.mem_we;
   assign pc_ld   = cw.pc_ld;
   assign out_ld  = cw.out_ld;
   assign halted  = cw.halted;

endmodule

// File: rtl/cpu_seq_ctrl_chk.sv
module cpu_seq_ctrl_chk #(
   parameter int ADDR_W = 4
) (
   input logic              clk,
   input logic              rst,
   input logic              pc_oe,
   input logic              mar_ld,
   input logic              mem_oe,
   input logic              ir_ld,
   input logic              pc_inc,
   input logic              ir_oe,
   input logic              a_oe,
   input logic              pc_ld,
   input logic              mem_we,
   input logic              halted,
   input logic [ADDR_W-1:0] pc
);

   assert_reset_entry_R1: assert property (@(posedge clk)
      rst |=> (pc_oe && mar_ld && !halted));

   assert_fetch_pair_R3: assert property (@(posedge clk) disable iff (rst)
      (pc_oe && mar_ld) |=> (mem_oe && ir_ld && pc_inc));

   assert_jump_returns_R10: assert property (@(posedge clk) disable iff (rst)
      pc_ld |=> (pc_oe && mar_ld));

   assert_halt_stays_R6: assert property (@(posedge clk) disable iff (rst)
      halted |=> halted);

   assert_halt_quiet_R6: assert property (@(posedge clk) disable iff (rst)
      halted |-> !(pc_oe || mem_oe || ir_oe || a_oe || mar_ld || ir_ld ||
                   pc_inc || pc_ld || mem_we));

   assert_halt_pc_frozen_R6: assert property (@(posedge clk) disable iff (rst)
      halted |=> $stable(pc));

   assert_one_driver_R8: assert property (@(posedge clk) disable iff (rst)
      $countones({pc_oe, mem_oe, ir_oe, a_oe}) <= 1);

endmodule

bind cpu_seq_ctrl cpu_seq_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk    (clk),
   .rst    (rst),
   .pc_oe  (pc_oe),
   .mar_ld (mar_ld),
   .mem_oe (mem_oe),
   .ir_ld  (ir_ld),
   .pc_inc (pc_inc),
   .ir_oe  (ir_oe),
   .a_oe   (a_oe),
   .pc_ld  (pc_ld),
   .mem_we (mem_we),
   .halted (halted),
   .pc     (pc)
);

// File: tb/cpu_seq_ctrl_tb.sv
module cpu_seq_ctrl_tb;

   localparam int DW = 8;
   localparam int AW = 4;

   localparam int M_PC_OE   = 1 << 0;
   localparam int M_MAR_LD  = 1 << 1;
   localparam int M_MEM_OE  = 1 << 2;
   localparam int M_IR_LD   = 1 << 3;
   localparam int M_PC_INC  = 1 << 4;
   localparam int M_IR_OE   = 1 << 5;
   localparam int M_A_LD    = 1 << 6;
   localparam int M_B_LD    = 1 << 7;
   localparam int M_ALU_WR  = 1 << 8;
   localparam int M_ALU_SUB = 1 << 9;
   localparam int M_A_OE    = 1 << 10;
   localparam int M_MEM_WE  = 1 << 11;
   localparam int M_PC_LD   = 1 << 12;
   localparam int M_OUT_LD  = 1 << 13;
   localparam int M_HALT    = 1 << 14;
   localparam int W_F1      = M_PC_OE | M_MAR_LD;
   localparam int W_F2      = M_MEM_OE | M_IR_LD | M_PC_INC;
   localparam int W_DECODE  = -1;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #10 clk = ~clk;

   logic [DW-1:0] bus;
   logic pc_oe, mar_ld, mem_oe, ir_ld, pc_inc, ir_oe, a_ld, b_ld;
   logic alu_wr, alu_sub, a_oe, mem_we, pc_ld, out_ld, halted;
   logic [AW-1:0] pc;

   cpu_seq_ctrl #(.DATA_W(DW), .OPC_W(4), .ADDR_W(AW)) u_dut (
      .clk(clk), .rst(rst), .bus_in(bus),
      .pc_oe(pc_oe), .mar_ld(mar_ld), .mem_oe(mem_oe), .ir_ld(ir_ld),
      .pc_inc(pc_inc), .ir_oe(ir_oe), .a_ld(a_ld), .b_ld(b_ld),
      .alu_wr(alu_wr), .alu_sub(alu_sub), .a_oe(a_oe), .mem_we(mem_we),
      .pc_ld(pc_ld), .out_ld(out_ld), .halted(halted), .pc(pc)
   );

   // Minimal datapath driven by the strobes.
   logic [7:0] mem [16];
   logic [3:0] mar = '0;
   logic [7:0] ir = '0, acc = '0, opb = '0, outr = '0;

   always_comb begin
      bus = '0;
      if (pc_oe)       bus = {4'h0, pc};
      else if (mem_oe) bus = mem[mar];
      else if (ir_oe)  bus = {4'h0, ir[3:0]};
      else if (a_oe)   bus = acc;
   end

   always @(posedge clk) begin
      if (mar_ld) mar <= bus[3:0];
      if (ir_ld)  ir  <= bus;
      if (b_ld)   opb <= bus;
      if (a_ld)   acc <= bus;
      if (alu_wr) acc <= alu_sub ? acc - bus : acc + bus;
      if (mem_we) mem[mar] <= bus;
      if (out_ld) outr <= bus;
   end

   int total = 0;
   int bad = 0;
   bit done = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int act_word();
      return {17'd0, halted, out_ld, pc_ld, mem_we, a_oe, alu_sub, alu_wr,
              b_ld, a_ld, ir_oe, pc_inc, ir_ld, mem_oe, mar_ld, pc_oe};
   endfunction

   // Behavioural reference: a queue of expected control words per cycle.
   int         wq[$];
   string      tq[$];
   logic [3:0] rpc;
   logic [3:0] jtarget;
   bit         rhalt;
   logic [3:0] pc_early;

   task automatic ref_cycle(input bit have_early);
      int    ex;
      string tag;
      logic [7:0] instr;
      if (wq.size() == 0) begin
         if (rhalt) begin
            wq.push_back(M_HALT); tq.push_back("R6");
         end else begin
            wq.push_back(W_F1); tq.push_back("R2");
            wq.push_back(W_DECODE); tq.push_back("R3");
         end
      end
      ex  = wq.pop_front();
      tag = tq.pop_front();
      if (ex == W_DECODE) begin
         instr = mem[rpc];
         if (have_early) chk(pc_early == rpc, "R5 early", pc_early, rpc);
         rpc = rpc + 4'd1;
         ex  = W_F2;
         case (instr[7:4])
            4'h1: begin
               wq.push_back(M_IR_OE | M_MAR_LD); tq.push_back("R4");
               wq.push_back(M_MEM_OE | M_A_LD);  tq.push_back("R4");
            end
            4'h2: begin
               wq.push_back(M_IR_OE | M_MAR_LD); tq.push_back("R4");
               wq.push_back(M_MEM_OE | M_B_LD | M_ALU_WR); tq.push_back("R4");
            end
            4'h3: begin
               wq.push_back(M_IR_OE | M_MAR_LD); tq.push_back("R4");
               wq.push_back(M_MEM_OE | M_B_LD | M_ALU_WR | M_ALU_SUB); tq.push_back("R4");
            end
            4'h4: begin
               wq.push_back(M_IR_OE | M_MAR_LD); tq.push_back("R4");
               wq.push_back(M_A_OE | M_MEM_WE);  tq.push_back("R4");
            end
            4'h5: begin wq.push_back(M_IR_OE | M_A_LD); tq.push_back("R10"); end
            4'h6: begin
               wq.push_back(M_IR_OE | M_PC_LD); tq.push_back("R10");
               jtarget = instr[3:0];
            end
            4'hE: begin wq.push_back(M_A_OE | M_OUT_LD); tq.push_back("R10"); end
            4'hF: rhalt = 1'b1;
            default: begin
               wq.push_back(W_F1); tq.push_back("R7");
               wq.push_back(W_DECODE); tq.push_back("R3");
            end
         endcase
      end
      if ((ex & M_PC_LD) != 0) rpc = jtarget;
      chk(act_word() == ex, tag, act_word(), ex);
      chk(pc == rpc, "R5", pc, rpc);
      chk($countones({pc_oe, mem_oe, ir_oe, a_oe}) <= 1, "R8", act_word(), 0);
   endtask

   // Releases reset, then compares every cycle until halt+4 or max_cyc.
   task automatic run_prog(input int max_cyc, output int hcyc);
      wq.delete(); tq.delete();
      rpc = '0; rhalt = 1'b0; hcyc = -1;
      @(posedge clk); #5 rst = 1'b0; #10;
      for (int c = 1; c <= max_cyc; c++) begin
         if (c > 1) begin
            @(posedge clk); #5 pc_early = pc; #10;
         end
         ref_cycle(c > 1);
         if (halted && hcyc < 0) hcyc = c;
         if (hcyc >= 0 && c >= hcyc + 4) break;
      end
   endtask

   task automatic apply_reset();
      rst = 1'b1;
      repeat (2) @(posedge clk);
      #15;
      chk(act_word() == W_F1, "R1", act_word(), W_F1);
      chk(pc == 4'd0, "R1 pc", pc, 0);
   endtask

   task automatic load_sum_prog();
      for (int i = 0; i < 16; i++) mem[i] = 8'h00;
      mem[0]  = 8'h1E;  // load A from 14
      mem[1]  = 8'h2F;  // add 15
      mem[2]  = 8'hE0;  // output
      mem[3]  = 8'hF0;  // halt
      mem[14] = 8'd28;
      mem[15] = 8'd14;
   endtask

   task automatic load_mix_prog();
      for (int i = 0; i < 16; i++) mem[i] = 8'h00;
      mem[0]  = 8'h55;  // A = 5
      mem[1]  = 8'h3D;  // A -= mem[13] -> 2
      mem[2]  = 8'h4C;  // mem[12] = 2
      mem[3]  = 8'h70;  // unknown opcode
      mem[4]  = 8'h66;  // jump to 6
      mem[5]  = 8'hE0;  // skipped output
      mem[6]  = 8'h1C;  // A = mem[12]
      mem[7]  = 8'h2D;  // A += 3 -> 5
      mem[8]  = 8'hE0;  // output 5
      mem[9]  = 8'h00;  // opcode 0 no-op
      mem[10] = 8'hF0;  // halt
      mem[13] = 8'h03;
   endtask

   initial begin
      int hc;
      load_sum_prog();
      apply_reset();
      chk(halted == 1'b0, "R1 halted", halted, 0);

      // Reset arriving during the address cycle of the add instruction.
      run_prog(7, hc);
      chk(act_word() == (M_IR_OE | M_MAR_LD), "R4 mid", act_word(), M_IR_OE | M_MAR_LD);
      apply_reset();

      run_prog(40, hc);
      chk(hc > 0 && hc <= 16, "R9 halt cycle", hc, 16);
      chk(outr == 8'd42, "R9 output", outr, 42);
      chk(halted == 1'b1, "R6 still halted", halted, 1);

      // Reset leaves halt; second program.
      load_mix_prog();
      apply_reset();
      chk(halted == 1'b0, "R6 reset exit", halted, 0);
      run_prog(80, hc);
      chk(hc > 0, "R6 reached", hc, 1);
      chk(outr == 8'd5, "R10 output", outr, 5);
      chk(mem[12] == 8'd2, "R4 store", mem[12], 2);
      chk(acc == 8'd5, "R4 alu", acc, 5);

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog expired act=running exp=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule